// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls 96 pads organised as three banks of 32. Every pad carries a 2-bit function selector. Code 3 selects general-purpose I/O, and any other code hands the pad to another function. For GPIO pads the block holds output data and output-enable bits. It also resolves the level the pin presents. When that level changes, it emits a one-cycle change pulse. Pad inputs are synchronised. A change on a pad can raise a per-pin status bit, and the status bits feed one interrupt line per bank.

Software uses a plain 32-bit register port: byte address, write data, write strobe and combinational read data. The port has no back-pressure. A write takes effect on the clock edge where the strobe is high, and a read returns data in the same cycle the address is presented. Per-bank registers are located by a register code and a bank index in the address. Selector words sit in their own address range.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every selector field reads 3 (selector words read 0xFFFFFFFF), every pull word reads 0xFFFFFFFF, and input, output, enable, interrupt-routing, level-mode, polarity and status words read 0. All `pin_val` bits are 1, and `irq` and `pad_oe` are 0.
- R2: A register is decoded only at a word-aligned byte address (bits 3:0 zero). Per-bank registers sit at (code << 8) | (bank << 4) with these codes: pull 4, output data 5, input data 6, output enable 7, interrupt routing 8, interrupt enable 9, level mode 0xA, polarity 0xB, status 0xC. Selector word i sits at 0x100 + 16*i, and pin n uses bits 2*(n%16)+1:2*(n%16) of word n/16. Writable words read back what was written. Addresses outside the map read 0.
- R3: `pad_out` carries the output data bits. A `pad_oe` bit is 1 only when its enable bit is 1 and its selector is 3. A `pin_val` bit equals the output data bit when the enable bit is set, and 1 otherwise.
- R4: `pin_val` updates on the clock edge after the register write that changes it. `pin_chg` is high for exactly that one cycle, and only on the pins whose value changed.
- R5: Each pad input passes through two flops. The input data word shows a pad change after the second rising edge.
- R6: For a GPIO pin with level mode 0 and routing 1, the status bit sets on the third rising edge after a pad change, but only if the new level equals the pin's polarity bit.
- R7: A pin whose selector is not 3 never sets its status bit.
- R8: A pin with routing bit 0 never sets its status bit.
- R9: `irq[b]` is the OR over bank b of (status AND interrupt enable). Other banks are unaffected.
- R10: Writing the status word clears the bits written as 1 and leaves the others alone. If an edge sets a bit on the same edge that software clears it, the bit stays set.
- R11: When a pin's level-mode bit is 1, its status bit follows (GPIO AND routing AND input level equals polarity) every cycle. Writing 1 to clear it has no lasting effect while that condition holds.
- R12: Pull words are storage only. Writing them changes none of `pad_out`, `pad_oe`, `pin_val` or `pin_chg`.
- R13: The input data word is read-only. Writes to it leave its read value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | 96 | Pad input levels |
| pad_out | output | 96 | Pad output data |
| pad_oe | output | 96 | Pad output enable |
| pin_val | output | 96 | Resolved pin level |
| pin_chg | output | 96 | One-cycle pulse when a resolved level changes |
| irq | output | 3 | Per-bank interrupt line |

## Verification
Two functions can act on the same status bit in the same cycle: an input edge that sets it and a software write that clears it. The bench sets the bit once and then releases the pad. It raises the pad again and times a status write so that the write lands on the third rising edge after that pad change. That is the edge where the new detection registers. The status bit must still read 1 afterwards, and a later plain clear write must bring it to 0. The same sequence is then repeated in level mode, where a clear write must not stick while the active level is held.

// File: rtl/gpmx_pkg.sv
package gpmx_pkg;
  localparam int WORD_W       = 32;
  localparam int ADDR_W       = 12;
  localparam int FLD_W        = 2;
  localparam int FLD_PER_WORD = WORD_W / FLD_W;
  localparam logic [FLD_W-1:0] FN_GPIO = 2'd3;

  typedef enum logic [3:0] {
    RC_MUX  = 4'h1,
    RC_PULL = 4'h4,
    RC_OUT  = 4'h5,
    RC_DIN  = 4'h6,
    RC_OE   = 4'h7,
    RC_ROUT = 4'h8,
    RC_IEN  = 4'h9,
    RC_LVL  = 4'hA,
    RC_POL  = 4'hB,
    RC_STAT = 4'hC
  } rcode_e;

  typedef struct packed {
    logic [WORD_W-1:0] pull;
    logic [WORD_W-1:0] dout;
    logic [WORD_W-1:0] din;
    logic [WORD_W-1:0] oe;
    logic [WORD_W-1:0] rout;
    logic [WORD_W-1:0] ien;
    logic [WORD_W-1:0] lvl;
    logic [WORD_W-1:0] pol;
    logic [WORD_W-1:0] stat;
  } bank_view_t;
endpackage

// File: rtl/gpmx_sync.sv
module gpmx_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpmx_bank.sv
module gpmx_bank
  import gpmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [3:0]        code_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] gpio_i,
  input  logic [WORD_W-1:0] din_i,
  output bank_view_t        view_o,
  output logic [WORD_W-1:0] pad_out_o,
  output logic [WORD_W-1:0] pad_oe_o,
  output logic [WORD_W-1:0] pin_val_o,
  output logic [WORD_W-1:0] pin_chg_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] pull_q, out_q, oe_q, rout_q, ien_q, lvl_q, pol_q, stat_q;
  logic [WORD_W-1:0] prev_q, val_q, chg_q;
  logic [WORD_W-1:0] in_chg, in_match, edge_set, lvl_hit, clr, stat_n, eff;
  logic wr_pull, wr_out, wr_oe, wr_rout, wr_ien, wr_lvl, wr_pol, wr_stat;

  assign wr_pull = we_i && (code_i == RC_PULL);
  assign wr_out  = we_i && (code_i == RC_OUT);
  assign wr_oe   = we_i && (code_i == RC_OE);
  assign wr_rout = we_i && (code_i == RC_ROUT);
  assign wr_ien  = we_i && (code_i == RC_IEN);
  assign wr_lvl  = we_i && (code_i == RC_LVL);
  assign wr_pol  = we_i && (code_i == RC_POL);
  assign wr_stat = we_i && (code_i == RC_STAT);

  // input event detection on the synchronised level
  always_comb begin
    in_chg   = din_i ^ prev_q;
    in_match = ~(din_i ^ pol_q);
    edge_set = gpio_i & rout_q & ~lvl_q & in_chg & in_match;
    lvl_hit  = gpio_i & rout_q & lvl_q & in_match;
    clr      = wr_stat ? wdata_i : '0;
    stat_n   = lvl_hit | (~lvl_q & ((stat_q & ~clr) | edge_set));
    eff      = (oe_q & out_q) | ~oe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_q <= '1;
      out_q  <= '0;
      oe_q   <= '0;
      rout_q <= '0;
      ien_q  <= '0;
      lvl_q  <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      prev_q <= '0;
      val_q  <= '1;
      chg_q  <= '0;
    end else begin
      if (wr_pull) pull_q <= wdata_i;
      if (wr_out)  out_q  <= wdata_i;
      if (wr_oe)   oe_q   <= wdata_i;
      if (wr_rout) rout_q <= wdata_i;
      if (wr_ien)  ien_q  <= wdata_i;
      if (wr_lvl)  lvl_q  <= wdata_i;
      if (wr_pol)  pol_q  <= wdata_i;
      stat_q <= stat_n;
      prev_q <= din_i;
      val_q  <= eff;
      chg_q  <= eff ^ val_q;
    end
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = oe_q & gpio_i;
  assign pin_val_o = val_q;
  assign pin_chg_o = chg_q;
  assign irq_o     = |(stat_q & ien_q);

  always_comb begin
    view_o.pull = pull_q;
    view_o.dout = out_q;
    view_o.din  = din_i;
    view_o.oe   = oe_q;
    view_o.rout = rout_q;
    view_o.ien  = ien_q;
    view_o.lvl  = lvl_q;
    view_o.pol  = pol_q;
    view_o.stat = stat_q;
  end

  // R4
  chg_means_move_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_q != '0) |-> (val_q != $past(val_q)));

  // R7
  mux_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(gpio_i)) == '0));

  // R8
  route_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(rout_q)) == '0));

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_set != '0) |=> ((stat_q & $past(edge_set)) == $past(edge_set)));
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpmx_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  output logic [WORD_W-1:0]       bus_rdata,
  input  logic [NBANK*WORD_W-1:0] pad_in,
  output logic [NBANK*WORD_W-1:0] pad_out,
  output logic [NBANK*WORD_W-1:0] pad_oe,
  output logic [NBANK*WORD_W-1:0] pin_val,
  output logic [NBANK*WORD_W-1:0] pin_chg,
  output logic [NBANK-1:0]        irq
);
  localparam int NPIN = NBANK * WORD_W;
  localparam int NMUX = NPIN / FLD_PER_WORD;

  logic [3:0]        code;
  logic [3:0]        idx;
  logic              aligned;
  logic [WORD_W-1:0] mux_q [NMUX];
  logic [NPIN-1:0]   gpio_m;
  logic [NPIN-1:0]   din_s;
  bank_view_t        views [NBANK];

  assign code    = bus_addr[11:8];
  assign idx     = bus_addr[7:4];
  assign aligned = (bus_addr[3:0] == 4'h0);

  genvar m, p, b;
  generate
    for (m = 0; m < NMUX; m++) begin : g_mux
      always_ff @(posedge clk) begin
        if (rst) mux_q[m] <= '1;
        else if (bus_we && aligned && code == RC_MUX && idx == 4'(m))
          mux_q[m] <= bus_wdata;
      end
    end

    for (p = 0; p < NPIN; p++) begin : g_fn
      assign gpio_m[p] =
        (mux_q[p / FLD_PER_WORD][(p % FLD_PER_WORD)*FLD_W +: FLD_W] == FN_GPIO);
    end
  endgenerate

  gpmx_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_in),
    .q_o (din_s)
  );

  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      gpmx_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .we_i      (bus_we && aligned && idx == 4'(b)),
        .code_i    (code),
        .wdata_i   (bus_wdata),
        .gpio_i    (gpio_m[b*WORD_W +: WORD_W]),
        .din_i     (din_s[b*WORD_W +: WORD_W]),
        .view_o    (views[b]),
        .pad_out_o (pad_out[b*WORD_W +: WORD_W]),
        .pad_oe_o  (pad_oe[b*WORD_W +: WORD_W]),
        .pin_val_o (pin_val[b*WORD_W +: WORD_W]),
        .pin_chg_o (pin_chg[b*WORD_W +: WORD_W]),
        .irq_o     (irq[b])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (code == RC_MUX) begin
        for (int i = 0; i < NMUX; i++)
          if (idx == 4'(i)) bus_rdata = mux_q[i];
      end else begin
        for (int i = 0; i < NBANK; i++) begin
          if (idx == 4'(i)) begin
            case (code)
              RC_PULL: bus_rdata = views[i].pull;
              RC_OUT:  bus_rdata = views[i].dout;
              RC_DIN:  bus_rdata = views[i].din;
              RC_OE:   bus_rdata = views[i].oe;
              RC_ROUT: bus_rdata = views[i].rout;
              RC_IEN:  bus_rdata = views[i].ien;
              RC_LVL:  bus_rdata = views[i].lvl;
              RC_POL:  bus_rdata = views[i].pol;
              RC_STAT: bus_rdata = views[i].stat;
              default: bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: tb/gpio_mux_ctrl_tb.sv
module gpio_mux_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [95:0] pad_in = '0;
  logic [95:0] pad_out, pad_oe, pin_val, pin_chg;
  logic [2:0]  irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] r;

  always #2 clk = ~clk;

  gpio_mux_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_val(pin_val),
    .pin_chg(pin_chg), .irq(irq)
  );

  // {address, write data, expected read}
  localparam logic [75:0] VEC [0:9] = '{
    {12'h510, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {12'h720, 32'h0000FFFF, 32'h0000FFFF},
    {12'h600, 32'hFFFFFFFF, 32'h00000000},
    {12'hC00, 32'hFFFFFFFF, 32'h00000000},
    {12'h120, 32'h12345678, 32'h12345678},
    {12'hB10, 32'hDEADBEEF, 32'hDEADBEEF},
    {12'h900, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {12'hA20, 32'h80000001, 32'h80000001},
    {12'h430, 32'hFFFFFFFF, 32'h00000000},
    {12'h170, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 1'b0; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(12'h100, r); chk("R1 mux", r, 32'hFFFFFFFF);
    rd(12'h420, r); chk("R1 pull", r, 32'hFFFFFFFF);
    rd(12'h610, r); chk("R1 din", r, 0);
    rd(12'hC20, r); chk("R1 stat", r, 0);
    chk("R1 pin_val", pin_val, {96{1'b1}});
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 table walk (entries 3 and 4 exercise R13 and R10)
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], r);
      chk("R2 table", r, VEC[i][31:0]);
    end

    // R3 / R4 output path
    do_reset();
    wr(12'h510, 32'h000000F0);
    chk("R4 no change", pin_chg, 0);
    @(posedge clk); #1 chk("R4 no change later", pin_chg, 0);
    wr(12'h710, 32'h000000FF);
    chk("R4 before edge", pin_chg, 0);
    @(posedge clk); #1;
    chk("R4 pulse", pin_chg, {32'h0, 32'h0000000F, 32'h0});
    chk("R3 pin_val", pin_val[63:32], 32'hFFFFFFF0);
    @(posedge clk); #1 chk("R4 one cycle", pin_chg, 0);
    chk("R3 pad_out", pad_out[63:32], 32'h000000F0);
    chk("R3 pad_oe", pad_oe[63:32], 32'h000000FF);
    // R12 pull has no effect
    wr(12'h410, 32'h0);
    repeat (2) begin
      @(posedge clk); #1;
      chk("R12 chg", pin_chg, 0);
      chk("R12 val", pin_val[63:32], 32'hFFFFFFF0);
      chk("R12 oe", pad_oe[63:32], 32'h000000FF);
      chk("R12 out", pad_out[63:32], 32'h000000F0);
    end
    // R3 mux gating of pad_oe: pin 32 to function 0
    wr(12'h120, 32'hFFFFFFFC);
    #1 chk("R3 oe gated", pad_oe[63:32], 32'h000000FE);

    // R5 synchroniser
    do_reset();
    pad_in[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_addr = 12'h600; #1 chk("R5 one edge", bus_rdata, 0);
    @(posedge clk); #1 chk("R5 two edges", bus_rdata, 32'h20);
    // R13 din write ignored
    wr(12'h600, 32'h0);
    rd(12'h600, r); chk("R13 din", r, 32'h20);

    // R6 / R9 / R10 edge mode
    do_reset();
    wr(12'h800, 32'hFFFFFFFF);
    wr(12'h900, 32'h00000020);
    wr(12'hB00, 32'h00000220);
    @(negedge clk); pad_in[5] = 1'b1;
    repeat (2) @(posedge clk); #1 chk("R6 not yet", irq, 0);
    @(posedge clk); #1 chk("R9 irq bank0", irq, 3'b001);
    rd(12'hC00, r); chk("R6 stat set", r, 32'h20);
    pad_in[6] = 1'b1; settle3();
    rd(12'hC00, r); chk("R6 wrong polarity", r, 32'h20);
    pad_in[6] = 1'b0; settle3();
    rd(12'hC00, r); chk("R6 falling match", r, 32'h60);
    wr(12'hC00, 32'h20);
    rd(12'hC00, r); chk("R10 w1c", r, 32'h40);
    chk("R9 irq off", irq, 0);
    // R10 set beats clear on the same edge
    pad_in[9] = 1'b1; settle3();
    pad_in[9] = 1'b0; settle3();
    rd(12'hC00, r); chk("R10 setup", r, 32'h240);
    wr(12'hC00, 32'h200);
    @(negedge clk); pad_in[9] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); bus_addr = 12'hC00; bus_wdata = 32'h200; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(12'hC00, r); chk("R10 set wins", r, 32'h240);
    wr(12'hC00, 32'h200);
    rd(12'hC00, r); chk("R10 later clear", r, 32'h40);

    // R7 non-GPIO pin
    do_reset();
    wr(12'h800, 32'hFFFFFFFF);
    wr(12'h900, 32'hFFFFFFFF);
    wr(12'hB00, 32'h00000080);
    wr(12'h100, 32'hFFFF3FFF);
    @(negedge clk); pad_in[7] = 1'b1; settle3();
    rd(12'hC00, r); chk("R7 stat", r, 0);
    chk("R7 irq", irq, 0);

    // R8 routing bit off
    do_reset();
    wr(12'h800, 32'hFFFFFEFF);
    wr(12'h900, 32'h00000100);
    wr(12'hB00, 32'h00000100);
    @(negedge clk); pad_in[8] = 1'b1; settle3();
    rd(12'hC00, r); chk("R8 stat", r, 0);
    chk("R8 irq", irq, 0);

    // R9 bank isolation
    do_reset();
    wr(12'h820, 32'h00000008);
    wr(12'h920, 32'h00000008);
    wr(12'hB20, 32'h00000008);
    @(negedge clk); pad_in[67] = 1'b1; settle3();
    chk("R9 bank2 only", irq, 3'b100);

    // R11 level mode
    do_reset();
    wr(12'hB10, 32'h00000100);
    wr(12'hA10, 32'h00000100);
    wr(12'h910, 32'h00000100);
    wr(12'h810, 32'hFFFFFFFF);
    @(negedge clk); pad_in[40] = 1'b1; settle3();
    rd(12'hC10, r); chk("R11 active", r, 32'h100);
    chk("R11 irq", irq, 3'b010);
    wr(12'hC10, 32'h100);
    @(posedge clk); @(negedge clk);
    rd(12'hC10, r); chk("R11 clear no stick", r, 32'h100);
    pad_in[40] = 1'b0; settle3();
    rd(12'hC10, r); chk("R11 follows", r, 0);
    chk("R11 irq off", irq, 0);

    finish_up();
  end
endmodule